// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block receives characters from an asynchronous serial line. An enable pulse from outside runs at sixteen times the bit rate. A character frame is a low start bit, seven or eight data bits sent least significant bit first, an optional even or odd parity bit, and one or two high stop bits. Each character that is received goes into a data register. A clean character also sets a data-full flag.

Software uses a small register bus to set up the frame format, read status and data, and clear the error flags. A framing error or a parity error sets a sticky flag. Software clears that flag by reading it as 1 and then writing 0 to it. While either flag is set, the receiver takes no new characters. This lets software handle the bad character before any more traffic arrives.

Top module: `uart_rx_sticky`

## Requirements
- R1: A falling edge on the line starts a frame only if the line is still low at the middle of the start bit, eight oversample ticks later. Otherwise the receiver returns to idle and nothing is loaded.
- R2: Data bits are sampled at their centres, least significant bit first. The character reads back from the data register at address 2, with bit 7 reading 0 in 7-bit mode. A clean character sets the full flag, which is status bit 0 at address 1. A bus read of address 2 clears the full flag.
- R3: When parity is enabled, the parity-error flag (status bit 2) is set if the number of 1s across the data bits and the parity bit does not match the selected parity (even: total even, odd: total odd). When parity is disabled, no parity bit is expected and the flag is never set.
- R4: The framing-error flag (status bit 1) is set when the first stop bit is sampled as 0. With two stop bits configured, the second stop bit is never checked.
- R5: A character with a framing or parity error is still loaded into the data register, but the full flag is not set.
- R6: While either error flag is 1, no new character is received. The data register and the full flag keep their values.
- R7: An error flag clears only when a write of 0 to its bit at address 1 follows a status read that returned that bit as 1. A write of 0 with no such read leaves the flag set. Writing 1 to any status bit has no effect.
- R8: Clearing the enable bit leaves both error flags unchanged. While the receiver is disabled, line activity loads nothing.
- R9: After reset, the control, status and data registers all read 0.
- R10: When the first stop bit is sampled low, the receiver waits for the line to go high before it looks for another start bit.
- R11: The control register at address 0 holds: bit 0 receive enable, bit 1 seven-bit mode, bit 2 parity enable, bit 3 odd parity, bit 4 two stop bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | Enable pulse at sixteen times the bit rate |
| rxd | input | 1 | Serial receive line, idles high |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |

## Verification
The case that is hardest to reach is a framing error where the line stays low after the stop bit. To show that the receiver does not treat that low level as a new start bit, the flag must be cleared by a read and a write of 0 while the line is still low. The bench holds the line low through the stop bit and performs that clear. It then keeps the line low for several more bit times, releases it, and sends a clean character. If the receiver had started early, it would have produced a second framing error and a different data value.

// File: rtl/uart_rx_sticky.sv
module uart_rx_sticky #(
  parameter int OSR = 16,
  parameter int AW  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          os_tick,
  input  logic          rxd,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(1);
  localparam logic [AW-1:0] A_DATA = AW'(2);

  localparam logic [2:0] S_IDLE = 3'd0, S_START = 3'd1, S_DATA = 3'd2,
                         S_PAR = 3'd3, S_STOP1 = 3'd4, S_STOP2 = 3'd5,
                         S_WAITHI = 3'd6;

  logic rx_q1, rx_s;
  logic rx_en, len7, par_en, par_odd, stop2;
  logic [2:0] st;
  logic [CW-1:0] cnt;
  logic [2:0] bitn;
  logic [7:0] sr, rdr;
  logic par_bit;
  logic full, fer, per, fer_seen, per_seen;

  wire rd       = bus_sel && !bus_wr;
  wire wr       = bus_sel && bus_wr;
  wire wr_ctrl  = wr && bus_addr == A_CTRL;
  wire wr_stat  = wr && bus_addr == A_STAT;
  wire rd_stat  = rd && bus_addr == A_STAT;
  wire rd_data  = rd && bus_addr == A_DATA;
  wire err_any  = fer || per;
  wire tick     = rx_en && os_tick;
  wire at_last  = cnt == LAST;
  wire [2:0] last_bit = len7 ? 3'd6 : 3'd7;
  wire stop_smp = tick && st == S_STOP1 && at_last;
  wire [7:0] chr = len7 ? {1'b0, sr[7:1]} : sr;
  wire par_bad  = par_en && ((^chr ^ par_bit) != par_odd);
  wire fer_hit  = stop_smp && !rx_s;
  wire clr_fer  = wr_stat && !bus_wdata[1] && fer_seen;
  wire clr_per  = wr_stat && !bus_wdata[2] && per_seen;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_q1 <= 1'b1;
      rx_s  <= 1'b1;
    end else begin
      rx_q1 <= rxd;
      rx_s  <= rx_q1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {stop2, par_odd, par_en, len7, rx_en} <= '0;
    end else if (wr_ctrl) begin
      {stop2, par_odd, par_en, len7, rx_en} <= bus_wdata[4:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      bitn    <= '0;
      sr      <= '0;
      par_bit <= 1'b0;
    end else if (!rx_en) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else if (os_tick) begin
      case (st)
        S_IDLE:
          if (!err_any && !rx_s) begin
            st  <= S_START;
            cnt <= '0;
          end
        S_START:
          if (cnt == MID) begin
            cnt  <= '0;
            bitn <= '0;
            st   <= rx_s ? S_IDLE : S_DATA;
          end else cnt <= cnt + 1'b1;
        S_DATA:
          if (at_last) begin
            cnt  <= '0;
            sr   <= {rx_s, sr[7:1]};
            bitn <= bitn + 1'b1;
            if (bitn == last_bit) st <= par_en ? S_PAR : S_STOP1;
          end else cnt <= cnt + 1'b1;
        S_PAR:
          if (at_last) begin
            cnt     <= '0;
            par_bit <= rx_s;
            st      <= S_STOP1;
          end else cnt <= cnt + 1'b1;
        S_STOP1:
          if (at_last) begin
            cnt <= '0;
            if (!rx_s)      st <= S_WAITHI;
            else if (stop2) st <= S_STOP2;
            else            st <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        S_STOP2:
          if (at_last) begin
            cnt <= '0;
            st  <= S_WAITHI;
          end else cnt <= cnt + 1'b1;
        S_WAITHI:
          if (rx_s) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rdr      <= '0;
      full     <= 1'b0;
      fer      <= 1'b0;
      per      <= 1'b0;
      fer_seen <= 1'b0;
      per_seen <= 1'b0;
    end else begin
      if (stop_smp) rdr <= chr;

      if (stop_smp && !fer_hit && !par_bad) full <= 1'b1;
      else if (rd_data)                     full <= 1'b0;

      if (fer_hit)      fer <= 1'b1;
      else if (clr_fer) fer <= 1'b0;
      if (fer_hit || clr_fer)  fer_seen <= 1'b0;
      else if (rd_stat && fer) fer_seen <= 1'b1;

      if (stop_smp && par_bad) per <= 1'b1;
      else if (clr_per)        per <= 1'b0;
      if ((stop_smp && par_bad) || clr_per) per_seen <= 1'b0;
      else if (rd_stat && per)              per_seen <= 1'b1;
    end

  always_comb
    case (bus_addr)
      A_CTRL:  bus_rdata = {3'b000, stop2, par_odd, par_en, len7, rx_en};
      A_STAT:  bus_rdata = {5'b00000, per, fer, full};
      A_DATA:  bus_rdata = rdr;
      default: bus_rdata = '0;
    endcase
endmodule

// File: rtl/uart_rx_sticky_chk.sv
module uart_rx_sticky_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] st,
  input logic       stop_smp,
  input logic       fer,
  input logic       per,
  input logic       full,
  input logic [7:0] rdr,
  input logic       rx_en,
  input logic       wr_stat,
  input logic       wbit1,
  input logic       wbit2
);
  localparam logic [2:0] C_IDLE = 3'd0, C_START = 3'd1;

  AST_FULL_ONLY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> !fer && !per) else $error("full set with error"); // R5

  AST_FER_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fer) |-> $past(stop_smp)) else $error("fer set outside stop"); // R4

  AST_PER_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(per) |-> $past(stop_smp)) else $error("per set outside stop"); // R3

  AST_NO_START_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_IDLE && (fer || per)) |=> st != C_START) else $error("start with error"); // R6

  AST_RDR_HELD_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (fer || per) |=> $stable(rdr)) else $error("data changed under error"); // R6

  AST_FER_CLEAR_BY_WR0: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fer) |-> $past(wr_stat) && !$past(wbit1)) else $error("fer cleared wrongly"); // R7

  AST_PER_CLEAR_BY_WR0: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(per) |-> $past(wr_stat) && !$past(wbit2)) else $error("per cleared wrongly"); // R7

  AST_EN_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rx_en) && !$past(stop_smp)) |-> $stable(fer) && $stable(per))
    else $error("flags moved on disable"); // R8
endmodule

bind uart_rx_sticky uart_rx_sticky_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .stop_smp(stop_smp),
  .fer(fer), .per(per), .full(full), .rdr(rdr), .rx_en(rx_en),
  .wr_stat(wr_stat), .wbit1(bus_wdata[1]), .wbit2(bus_wdata[2])
);

// File: tb/sim_uart_rx_sticky.sv
module sim_uart_rx_sticky;
  logic clk = 1'b0, rst_n = 1'b0, os_tick = 1'b1, rxd = 1'b1;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_rx_sticky u0 (.clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bwr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic brd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic expect_reg(string req, logic [1:0] a, logic [7:0] exp);
    logic [7:0] v;
    brd(a, v);
    chk(req, v, exp);
  endtask

  task automatic lbit(logic b);
    rxd = b;
    repeat (16) @(negedge clk);
  endtask

  task automatic frame(logic [7:0] d, int nb, bit pen, bit odd, bit badpar,
                       bit s1, bit two, bit s2);
    logic p;
    p = odd;
    lbit(1'b0);
    for (int i = 0; i < nb; i++) begin
      lbit(d[i]);
      p = p ^ d[i];
    end
    if (pen) lbit(p ^ badpar);
    lbit(s1);
    if (two) lbit(s2);
    rxd = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  task automatic t_reset;
    expect_reg("R9 ctrl", 2'd0, 8'h00);
    expect_reg("R9 stat", 2'd1, 8'h00);
    expect_reg("R9 data", 2'd2, 8'h00);
  endtask

  task automatic t_basic;
    bwr(2'd0, 8'h01);
    expect_reg("R11 ctrl readback", 2'd0, 8'h01);
    frame(8'hA5, 8, 0, 0, 0, 1, 0, 0);
    expect_reg("R2 full set", 2'd1, 8'h01);
    expect_reg("R2 data", 2'd2, 8'hA5);
    expect_reg("R2 full cleared by read", 2'd1, 8'h00);
    frame(8'h3C, 8, 0, 0, 0, 1, 0, 0);
    expect_reg("R3 no parity no per", 2'd1, 8'h01);
    expect_reg("R2 data 3C", 2'd2, 8'h3C);
  endtask

  task automatic t_seven_even;
    bwr(2'd0, 8'h07);
    frame(8'h5A, 7, 1, 0, 0, 1, 0, 0);
    expect_reg("R3 good even parity", 2'd1, 8'h01);
    expect_reg("R2 7-bit data", 2'd2, 8'h5A);
    frame(8'hFF, 7, 1, 0, 0, 1, 0, 0);
    expect_reg("R2 7-bit top bit 0", 2'd2, 8'h7F);
  endtask

  task automatic t_parity_err;
    bwr(2'd0, 8'h0D);
    frame(8'h3C, 8, 1, 1, 1, 1, 0, 0);
    expect_reg("R5 errored data loaded", 2'd2, 8'h3C);
    bwr(2'd1, 8'h00);
    expect_reg("R7 write0 without read keeps per", 2'd1, 8'h04);
    frame(8'h11, 8, 1, 1, 0, 1, 0, 0);
    expect_reg("R6 blocked stat", 2'd1, 8'h04);
    expect_reg("R6 blocked data", 2'd2, 8'h3C);
    bwr(2'd1, 8'h04);
    expect_reg("R7 write1 keeps per", 2'd1, 8'h04);
    bwr(2'd1, 8'h00);
    expect_reg("R7 read then write0 clears", 2'd1, 8'h00);
    bwr(2'd1, 8'hFF);
    expect_reg("R7 write1 cannot set", 2'd1, 8'h00);
    frame(8'h11, 8, 1, 1, 0, 1, 0, 0);
    expect_reg("R3 good odd parity", 2'd1, 8'h01);
    expect_reg("R3 odd data", 2'd2, 8'h11);
  endtask

  task automatic t_two_stop;
    bwr(2'd0, 8'h11);
    frame(8'h96, 8, 0, 0, 0, 1, 1, 0);
    expect_reg("R4 second stop ignored", 2'd1, 8'h01);
    expect_reg("R4 two-stop data", 2'd2, 8'h96);
  endtask

  task automatic t_framing;
    bwr(2'd0, 8'h01);
    frame(8'h42, 8, 0, 0, 0, 0, 0, 0);
    expect_reg("R4 fer set", 2'd1, 8'h02);
    expect_reg("R5 fer data loaded", 2'd2, 8'h42);
    bwr(2'd0, 8'h00);
    expect_reg("R8 disable keeps fer", 2'd1, 8'h02);
    bwr(2'd0, 8'h01);
    bwr(2'd1, 8'h00);
    expect_reg("R7 fer cleared", 2'd1, 8'h00);
  endtask

  task automatic t_glitch;
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (200) @(negedge clk);
    expect_reg("R1 glitch stat", 2'd1, 8'h00);
    expect_reg("R1 glitch data", 2'd2, 8'h42);
  endtask

  task automatic t_disabled;
    bwr(2'd0, 8'h00);
    frame(8'h77, 8, 0, 0, 0, 1, 0, 0);
    expect_reg("R8 disabled stat", 2'd1, 8'h00);
    expect_reg("R8 disabled data", 2'd2, 8'h42);
    bwr(2'd0, 8'h01);
  endtask

  task automatic t_wait_high;
    lbit(1'b0);
    for (int i = 0; i < 8; i++) lbit(i == 0 || i == 7);
    lbit(1'b0);
    rxd = 1'b0;
    expect_reg("R10 fer with low line", 2'd1, 8'h02);
    bwr(2'd1, 8'h00);
    expect_reg("R10 fer cleared while low", 2'd1, 8'h00);
    repeat (100) @(negedge clk);
    expect_reg("R10 no start while low", 2'd1, 8'h00);
    rxd = 1'b1;
    repeat (20) @(negedge clk);
    frame(8'h24, 8, 0, 0, 0, 1, 0, 0);
    expect_reg("R10 clean after release", 2'd1, 8'h01);
    expect_reg("R10 data after release", 2'd2, 8'h24);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_basic;
    t_seven_even;
    t_parity_err;
    t_two_stop;
    t_framing;
    t_glitch;
    t_disabled;
    t_wait_high;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule